// File: doc/BRIEF.md
# Early-Terminating Radix-4 Integer Divider

This block is a multi-cycle integer divider that yields either the quotient or the remainder of one division. Operands can be signed or unsigned, and the size can be 8, 16, 32 or 64 bits. A request is accepted on a clock edge where `start` is high and the unit is idle. The operands and the mode inputs are captured at that edge. The unit then stays busy until it raises `done` for one cycle, with `result` and `div_zero` valid.

Each iteration retires two quotient bits. Before iterating, the unit aligns the operands using leading-zero counts. Only as many iterations run as the significance of the result requires, so short quotients finish early.

The run has three fixed stages:
- operand extension and absolute value,
- normalisation, which includes the zero-divisor and small-dividend shortcuts,
- sign correction with result formatting.

The radix-4 iterations sit between the second and third stages. Only one division can be in progress at a time.

Top module: `rdiv_radix4`

## Requirements
- R1: For unsigned operation the quotient is floor(dividend/divisor), and the remainder is dividend minus quotient times divisor.
- R2: For signed operation the quotient is truncated toward zero, and a nonzero remainder has the sign of the dividend.
- R3: Size code 0/1/2/3 selects 8/16/32/64 bits. A code whose width exceeds XLEN acts as XLEN. Only the low width bits of each operand are used. The result is sign-extended to XLEN when signed and zero-extended when unsigned.
- R4: A signed division of the most negative value by -1 returns the most negative value as quotient and 0 as remainder.
- R5: A zero divisor sets `div_zero` in the done cycle and returns all ones as quotient and the formatted dividend as remainder. The done pulse follows the 3rd rising edge after acceptance.
- R6: Let k = bitlen(|dividend|) - bitlen(|divisor|) + 1 when |dividend| >= |divisor| and the divisor is nonzero; otherwise k = 0. `done` is high in the cycle after the (3 + ceil(k/2))-th rising edge following the accepting edge.
- R7: After reset, `busy` and `done` are low. `busy` is high from the edge that accepts a request until `done` rises. `done` lasts exactly one cycle, and `busy` is low in it.
- R8: A `start` pulse while `busy` is high is ignored: it changes neither the result nor the latency of the running division.
- R9: `div_zero` is low in the done cycle of any division with a nonzero divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request a division (taken only when idle) |
| dividend | input | XLEN | Dividend, low bits used per size |
| divisor | input | XLEN | Divisor, low bits used per size |
| op_size | input | 2 | Size code: 0=8, 1=16, 2=32, 3=64 bits |
| op_signed | input | 1 | 1 = signed operands |
| op_rem | input | 1 | 1 = return remainder, 0 = return quotient |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | XLEN | Quotient or remainder, extended to XLEN |
| div_zero | output | 1 | Divisor was zero (valid with done) |

## Verification
The bench builds the divider with XLEN = 16. At that width an 8-bit division takes at most four iterations, which makes a near-exhaustive sweep affordable. The sweep covers every 8-bit dividend against thirteen divisors chosen around zero, one, powers of two and both sign boundaries. Each pair is run in all four signed/unsigned, quotient/remainder combinations, with junk in the unused upper operand bits.

Directed 16-bit runs reach the longest eight-iteration latency, the signed overflow case, a zero divisor and a small-dividend shortcut. They also cover size codes above XLEN collapsing to 16 bits and a start pulse injected mid-run.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ABS,
    ST_NORM,
    ST_ITER,
    ST_FIX
  } rdiv_state_e;

  // Operand width in bits for a size code, clamped to the datapath width.
  function automatic int size_bits(input logic [1:0] code, input int xlen);
    int b;
    b = 8 << code;
    return (b > xlen) ? xlen : b;
  endfunction

endpackage

// File: rtl/rdiv_ext.sv
// Keeps the low size-bits of a value and extends them to the full width.
module rdiv_ext #(
  parameter int W = 64
) (
  input  logic [W-1:0] val,
  input  logic [1:0]   size,
  input  logic         is_signed,
  output logic [W-1:0] ext
);
  import rdiv_pkg::*;

  int          nb;
  logic [W-1:0] keep;
  logic         sbit;

  always_comb begin
    nb   = size_bits(size, W);
    keep = (nb >= W) ? '1 : ((W'(1) << nb) - W'(1));
    sbit = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (i == nb - 1) sbit = val[i];
    end
    ext = (is_signed && sbit) ? (val | ~keep) : (val & keep);
  end

endmodule

// File: rtl/rdiv_lzc.sv
// Leading-zero count; an all-zero input yields W.
module rdiv_lzc #(
  parameter  int W  = 64,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] zeros
);

  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (val[i]) zeros = CW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/rdiv_step.sv
// One radix-4 restoring step: shifts two dividend bits into the partial
// remainder and picks the largest digit 0..3 whose multiple fits.
module rdiv_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] rem_i,
  input  logic [1:0]   bits_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] rem_o,
  output logic [1:0]   dig_o
);
  localparam int EW = W + 2;

  logic [EW-1:0] pp, d1, d2, d3;

  always_comb begin
    pp = {rem_i, bits_i};
    d1 = {2'b00, den_i};
    d2 = d1 << 1;
    d3 = d1 + d2;
    if (pp >= d3) begin
      dig_o = 2'd3;
      rem_o = W'(pp - d3);
    end else if (pp >= d2) begin
      dig_o = 2'd2;
      rem_o = W'(pp - d2);
    end else if (pp >= d1) begin
      dig_o = 2'd1;
      rem_o = W'(pp - d1);
    end else begin
      dig_o = 2'd0;
      rem_o = W'(pp);
    end
  end

endmodule

// File: rtl/rdiv_radix4.sv
module rdiv_radix4 #(
  parameter  int XLEN = 64,
  localparam int CW   = $clog2(XLEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  input  logic [1:0]      op_size,
  input  logic            op_signed,
  input  logic            op_rem,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result,
  output logic            div_zero
);
  import rdiv_pkg::*;

  localparam int W = XLEN;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  // state
  rdiv_state_e st_q, st_d;
  logic        done_d, dzo_d;
  logic [W-1:0] res_d;

  logic [W-1:0] x_q, y_q, x_d, y_d;
  logic [1:0]   sz_q, sz_d;
  logic         sgn_q, sgn_d, rsel_q, rsel_d;
  logic [W-1:0] num_q, num_d, den_q, den_d, rem_q, rem_d, quo_q, quo_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic         nq_q, nq_d, nr_q, nr_d, dz_q, dz_d;
  logic         dp_en;

  // operand formatting and magnitude
  logic [W-1:0] a_ext, b_ext, a_mag, b_mag;
  logic         a_neg, b_neg;

  rdiv_ext #(.W(W)) u_ext_a (.val(x_q), .size(sz_q), .is_signed(sgn_q), .ext(a_ext));
  rdiv_ext #(.W(W)) u_ext_b (.val(y_q), .size(sz_q), .is_signed(sgn_q), .ext(b_ext));

  always_comb begin
    a_neg = sgn_q & a_ext[W-1];
    b_neg = sgn_q & b_ext[W-1];
    a_mag = a_neg ? (W'(0) - a_ext) : a_ext;
    b_mag = b_neg ? (W'(0) - b_ext) : b_ext;
  end

  // normalisation
  logic [CW-1:0] lz_num, lz_den, span, n_iter;
  logic [CW:0]   span_p2, sh_lo, sh_hi;

  rdiv_lzc #(.W(W)) u_lzc_num (.val(num_q), .zeros(lz_num));
  rdiv_lzc #(.W(W)) u_lzc_den (.val(den_q), .zeros(lz_den));

  always_comb begin
    span    = lz_den - lz_num;
    span_p2 = {1'b0, span} + (CW+1)'(2);
    n_iter  = span_p2[CW:1];
    sh_lo   = {n_iter, 1'b0};
    sh_hi   = (CW+1)'(W) - sh_lo;
  end

  // iteration step
  logic [W-1:0] step_rem;
  logic [1:0]   step_dig;

  rdiv_step #(.W(W)) u_step (
    .rem_i (rem_q),
    .bits_i(num_q[W-1:W-2]),
    .den_i (den_q),
    .rem_o (step_rem),
    .dig_o (step_dig)
  );

  // sign fix and output formatting
  logic [W-1:0] q_fix, r_fix, res_raw, res_fmt;

  always_comb begin
    q_fix = nq_q ? (W'(0) - quo_q) : quo_q;
    r_fix = nr_q ? (W'(0) - rem_q) : rem_q;
    if (dz_q) res_raw = rsel_q ? a_ext : '1;
    else      res_raw = rsel_q ? r_fix : q_fix;
  end

  rdiv_ext #(.W(W)) u_ext_res (.val(res_raw), .size(sz_q), .is_signed(sgn_q), .ext(res_fmt));

  // next state
  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    dzo_d  = div_zero;
    res_d  = result;
    x_d    = x_q;
    y_d    = y_q;
    sz_d   = sz_q;
    sgn_d  = sgn_q;
    rsel_d = rsel_q;
    num_d  = num_q;
    den_d  = den_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    nq_d   = nq_q;
    nr_d   = nr_q;
    dz_d   = dz_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_ABS;
          x_d    = dividend;
          y_d    = divisor;
          sz_d   = op_size;
          sgn_d  = op_signed;
          rsel_d = op_rem;
        end
      end
      ST_ABS: begin
        num_d = a_mag;
        den_d = b_mag;
        nq_d  = a_neg ^ b_neg;
        nr_d  = a_neg;
        st_d  = ST_NORM;
      end
      ST_NORM: begin
        dz_d  = (den_q == '0);
        quo_d = '0;
        if ((den_q == '0) || (num_q < den_q)) begin
          rem_d = num_q;
          st_d  = ST_FIX;
        end else begin
          rem_d = num_q >> sh_lo;
          num_d = num_q << sh_hi;
          cnt_d = n_iter;
          st_d  = ST_ITER;
        end
      end
      ST_ITER: begin
        num_d = {num_q[W-3:0], 2'b00};
        rem_d = step_rem;
        quo_d = {quo_q[W-3:0], step_dig};
        cnt_d = cnt_q - CW'(1);
        if (cnt_q == CW'(1)) st_d = ST_FIX;
      end
      ST_FIX: begin
        res_d  = res_fmt;
        dzo_d  = dz_q;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign dp_en = (st_q != ST_IDLE) || start;

  // control and output registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q     <= ST_IDLE;
      done     <= 1'b0;
      div_zero <= 1'b0;
      result   <= '0;
    end else begin
      st_q <= st_d;
      done <= done_d;
      if (st_q == ST_FIX) begin
        div_zero <= dzo_d;
        result   <= res_d;
      end
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (dp_en) begin
      x_q    <= x_d;
      y_q    <= y_d;
      sz_q   <= sz_d;
      sgn_q  <= sgn_d;
      rsel_q <= rsel_d;
      num_q  <= num_d;
      den_q  <= den_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      cnt_q  <= cnt_d;
      nq_q   <= nq_d;
      nr_q   <= nr_d;
      dz_q   <= dz_d;
    end
  end

  assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/rdiv_chk.sv
module rdiv_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic div_zero
);
  logic [7:0] busy_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_cycles <= '0;
    else if (!busy) busy_cycles <= '0;
    else            busy_cycles <= busy_cycles + 8'd1;
  end

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r6_min_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cycles >= 8'd3));

  a_r5_zero_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> (busy_cycles == 8'd3));

endmodule

bind rdiv_radix4 rdiv_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .div_zero(div_zero)
);

// File: tb/sim_rdiv_radix4.sv
module sim_rdiv_radix4;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic [1:0]   op_size = 2'd0;
  logic         op_signed = 1'b0;
  logic         op_rem = 1'b0;
  logic         busy, done, div_zero;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rdiv_radix4 #(.XLEN(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dividend(dividend), .divisor(divisor),
    .op_size(op_size), .op_signed(op_signed), .op_rem(op_rem),
    .busy(busy), .done(done), .result(result), .div_zero(div_zero)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int bitlen(input longint unsigned v);
    int n = 0;
    while (v != 0) begin
      n++;
      v = v >> 1;
    end
    return n;
  endfunction

  function automatic longint sx(input longint unsigned v, input int w, input bit s);
    longint unsigned m;
    m = v & ((64'd1 << w) - 64'd1);
    if (s && m[w-1]) return longint'(m) - longint'(64'd1 << w);
    return longint'(m);
  endfunction

  function automatic logic [W-1:0] fmt(input longint v, input int w, input bit s);
    return W'(sx(longint'(v), w, s));
  endfunction

  // One division; poke injects a start with other operands while busy (R8).
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] sz,
                     input bit s, input bit r, input bit poke);
    int w, lat, k, exp_lat;
    longint av, bv, ma, mb;
    logic [W-1:0] exp_res;
    bit exp_dz;
    w  = (sz == 2'd0) ? 8 : 16;
    av = sx(longint'(a), w, s);
    bv = sx(longint'(b), w, s);
    ma = (av < 0) ? -av : av;
    mb = (bv < 0) ? -bv : bv;
    if (bv == 0) begin
      exp_dz  = 1'b1;
      exp_res = r ? fmt(av, w, s) : fmt(-1, w, s);
      k = 0;
    end else begin
      exp_dz  = 1'b0;
      exp_res = r ? fmt(av % bv, w, s) : fmt(av / bv, w, s);
      k = (ma >= mb) ? (bitlen(longint'(ma)) - bitlen(longint'(mb)) + 1) : 0;
    end
    exp_lat = 3 + (k + 1) / 2;

    @(negedge clk);
    dividend = a; divisor = b; op_size = sz; op_signed = s; op_rem = r;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      dividend = ~a; divisor = 16'h0001; op_rem = ~r; start = 1'b1;
    end
    check(busy === 1'b1, "R7", "busy after accept", longint'(busy), 1);
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
    end while (!done && lat < 40);
    check(result === exp_res, (bv == 0) ? "R5" : (s ? "R2" : "R1"), "result",
          longint'(result), longint'(exp_res));
    check(div_zero === exp_dz, exp_dz ? "R5" : "R9", "div_zero",
          longint'(div_zero), longint'(exp_dz));
    check(lat == exp_lat, poke ? "R8" : "R6", "latency", longint'(lat), longint'(exp_lat));
    check(busy === 1'b0, "R7", "busy at done", longint'(busy), 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] dlist [13] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h05, 8'h07, 8'h10,
                               8'h33, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy === 1'b0, "R7", "busy in reset", longint'(busy), 0);
    check(done === 1'b0, "R7", "done in reset", longint'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy === 1'b0, "R7", "busy after reset", longint'(busy), 0);

    // R3: 8-bit sweep with junk in the upper operand bits
    for (int a = 0; a < 256; a++) begin
      for (int j = 0; j < 13; j++) begin
        for (int m = 0; m < 4; m++) begin
          run({8'hA5, 8'(a)}, {8'h3C, dlist[j]}, 2'd0, m[1], m[0], 1'b0);
        end
      end
    end

    // 16-bit directed cases
    run(16'hFFFF, 16'h0001, 2'd1, 1'b0, 1'b0, 1'b0);   // R6 longest
    run(16'hFFFF, 16'h0001, 2'd1, 1'b0, 1'b1, 1'b0);
    run(16'h8000, 16'hFFFF, 2'd1, 1'b1, 1'b0, 1'b0);   // R4
    run(16'h8000, 16'hFFFF, 2'd1, 1'b1, 1'b1, 1'b0);   // R4
    run(16'h1234, 16'h0000, 2'd1, 1'b1, 1'b0, 1'b0);   // R5
    run(16'h9234, 16'h0000, 2'd1, 1'b1, 1'b1, 1'b0);   // R5
    run(16'h9234, 16'h0000, 2'd1, 1'b0, 1'b0, 1'b0);   // R5
    run(16'hABCD, 16'h0123, 2'd1, 1'b1, 1'b0, 1'b0);
    run(16'hABCD, 16'h0123, 2'd1, 1'b1, 1'b1, 1'b0);
    run(16'hABCD, 16'h0123, 2'd1, 1'b0, 1'b1, 1'b0);
    run(16'h0005, 16'h1000, 2'd1, 1'b0, 1'b1, 1'b0);
    run(16'h7FFF, 16'h0003, 2'd3, 1'b1, 1'b0, 1'b0);   // R3 code above XLEN
    run(16'hC001, 16'h0007, 2'd2, 1'b1, 1'b1, 1'b0);   // R3 code above XLEN
    run(16'hFFF0, 16'h0003, 2'd1, 1'b0, 1'b0, 1'b1);   // R8 poke
    run(16'h8001, 16'h0005, 2'd1, 1'b1, 1'b1, 1'b1);   // R8 poke

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule